// File: doc/BRIEF.md
# Ripple-Slice Integer ALU with Signed Compare

This block is the arithmetic and logic unit of a simple integer datapath. It takes two operand words and a four-bit operation code and produces, with no clock, a result word, a flag that is set when the result is all zeros, and a flag for signed overflow. The zero flag lets a branch unit compare two registers for equality: it subtracts them and tests the flag.

The word is built from a row of identical one-bit slices. The carry out of each slice feeds the carry in of the next. A small decoder turns the operation code into a set of strobes. These strobes invert operand B and force the first carry-in to 1 for subtraction, and they select which slice output reaches the result. The top slice also works out signed overflow and a less-than bit. That less-than bit is routed back to the lowest slice, so a signed compare uses the same adder chain as subtraction.

Top module: `slt_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of A and B.
- R2: Operation code 4'b0001 gives the bitwise OR of A and B.
- R3: Operation code 4'b0010 gives A + B modulo 2^32.
- R4: Operation code 4'b0110 gives A - B modulo 2^32. It is computed as A + ~B + 1.
- R5: Operation code 4'b0111 gives 1 in bit 0 when A is less than B as signed two's-complement numbers, and 0 otherwise. Bits 31..1 are 0. The answer is correct even when A - B overflows.
- R6: For add and subtract, the overflow output is 1 exactly when the signed result does not fit in 32 bits.
- R7: For every operation code other than add and subtract, the overflow output is 0.
- R8: The zero output is 1 exactly when all 32 result bits are 0.
- R9: Any operation code not listed in R1 to R5 gives a result of 0, so the zero output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | All result bits are zero |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench aims at compares whose subtraction overflows, such as the most negative number against 1 and the most positive against -1. A design that takes only the sign of the difference would give the wrong answer in these cases. It also checks that overflow is raised only for add and subtract: a design that does not gate the flag would report overflow for a compare, or for AND of two large words. Carry chains are tested with all-ones plus one and with zero minus one, where a broken carry link gives a wrong high word. Unlisted codes are tested to confirm they give a zero result rather than some other function's output.

// File: rtl/slt_alu_pkg.sv
package slt_alu_pkg;
  localparam int unsigned WORD = 32;
  localparam int unsigned OPW  = 4;

  localparam logic [OPW-1:0] OP_AND = 4'b0000;
  localparam logic [OPW-1:0] OP_OR  = 4'b0001;
  localparam logic [OPW-1:0] OP_ADD = 4'b0010;
  localparam logic [OPW-1:0] OP_SUB = 4'b0110;
  localparam logic [OPW-1:0] OP_SLT = 4'b0111;

  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_e;

  typedef struct packed {
    logic  invertB;
    logic  carryIn;
    pick_e pick;
    logic  ovfEnable;
    logic  forceZero;
  } alu_strobes_t;
endpackage

// File: rtl/slt_alu_ctrl.sv
module slt_alu_ctrl
  import slt_alu_pkg::*;
#(
  parameter int unsigned OP_W = OPW
) (
  input  logic [OP_W-1:0] opCode,
  output alu_strobes_t    strobes
);
  always_comb begin
    strobes = '{invertB: 1'b0, carryIn: 1'b0, pick: PICK_AND,
                ovfEnable: 1'b0, forceZero: 1'b0};
    unique case (opCode)
      OP_AND: strobes.pick = PICK_AND;
      OP_OR:  strobes.pick = PICK_OR;
      OP_ADD: begin
        strobes.pick      = PICK_SUM;
        strobes.ovfEnable = 1'b1;
      end
      OP_SUB: begin
        strobes.pick      = PICK_SUM;
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.ovfEnable = 1'b1;
      end
      OP_SLT: begin
        strobes.pick    = PICK_LESS;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      default: strobes.forceZero = 1'b1;
    endcase
  end

  // Overflow reporting is confined to add and subtract.
  always_comb begin
    if (strobes.ovfEnable)
      assert_ovf_only_arith_R7: assert (opCode == OP_ADD || opCode == OP_SUB)
        else $error("overflow enabled for non-arithmetic code");
  end
endmodule

// File: rtl/slt_alu_slice.sv
module slt_alu_slice
  import slt_alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic  aBit,
  input  logic  bBit,
  input  logic  carryIn,
  input  logic  lessIn,
  input  logic  invertB,
  input  pick_e pick,
  output logic  resBit,
  output logic  carryOut,
  output logic  setOut,
  output logic  ovfOut
);
  logic bEff;
  logic sumBit;

  assign bEff     = bBit ^ invertB;
  assign sumBit   = aBit ^ bEff ^ carryIn;
  assign carryOut = (aBit & bEff) | (carryIn & (aBit ^ bEff));

  always_comb begin
    unique case (pick)
      PICK_AND:  resBit = aBit & bEff;
      PICK_OR:   resBit = aBit | bEff;
      PICK_SUM:  resBit = sumBit;
      PICK_LESS: resBit = lessIn;
      default:   resBit = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      assign ovfOut = carryIn ^ carryOut;
      assign setOut = sumBit ^ (carryIn ^ carryOut);
    end else begin : g_inner
      assign ovfOut = 1'b0;
      assign setOut = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/slt_alu_datapath.sv
module slt_alu_datapath
  import slt_alu_pkg::*;
#(
  parameter int unsigned W = WORD
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  alu_strobes_t strobes,
  output logic [W-1:0] result,
  output logic         zeroFlag,
  output logic         overflow
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] rawRes;
  logic         setTop;
  logic         ovfTop;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : stage
      logic cIn, cOut, rBit, sOut, oOut, lIn;
      if (i == 0) begin : g_first
        assign cIn = strobes.carryIn;
        assign lIn = setTop;
      end else begin : g_rest
        assign cIn = stage[i-1].cOut;
        assign lIn = 1'b0;
      end
      slt_alu_slice #(.IS_TOP(i == TOP)) u_slice (
        .aBit(opA[i]), .bBit(opB[i]), .carryIn(cIn), .lessIn(lIn),
        .invertB(strobes.invertB), .pick(strobes.pick),
        .resBit(rBit), .carryOut(cOut), .setOut(sOut), .ovfOut(oOut)
      );
      assign rawRes[i] = rBit;
    end
  endgenerate

  assign setTop   = stage[TOP].sOut;
  assign ovfTop   = stage[TOP].oOut;
  assign result   = strobes.forceZero ? '0 : rawRes;
  assign zeroFlag = ~|result;
  assign overflow = ovfTop & strobes.ovfEnable;

  always_comb begin
    if (strobes.pick == PICK_LESS && !strobes.forceZero)
      assert_slt_high_clear_R5: assert (result[W-1:1] == '0)
        else $error("compare result has high bits set");
    if (strobes.pick == PICK_LESS)
      assert_cmp_uses_sub_R4: assert (strobes.invertB && strobes.carryIn)
        else $error("compare not routed through subtract path");
  end
endmodule

// File: rtl/slt_alu.sv
module slt_alu
  import slt_alu_pkg::*;
#(
  parameter int unsigned W   = WORD,
  parameter int unsigned OPS = OPW
) (
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [OPS-1:0] opCode,
  output logic [W-1:0]   result,
  output logic           zeroFlag,
  output logic           overflow
);
  alu_strobes_t strobes;

  slt_alu_ctrl #(.OP_W(OPS)) u_ctrl (.opCode(opCode), .strobes(strobes));

  slt_alu_datapath #(.W(W)) u_dp (
    .opA(opA), .opB(opB), .strobes(strobes),
    .result(result), .zeroFlag(zeroFlag), .overflow(overflow)
  );

  always_comb begin
    if (overflow && opCode == OP_ADD)
      assert_add_ovf_signs_R6: assert (opA[W-1] == opB[W-1] && result[W-1] != opA[W-1])
        else $error("add overflow without sign condition");
    if (overflow && opCode == OP_SUB)
      assert_sub_ovf_signs_R6: assert (opA[W-1] != opB[W-1] && result[W-1] != opA[W-1])
        else $error("sub overflow without sign condition");
    if (zeroFlag)
      assert_zero_means_clear_R8: assert (result == '0)
        else $error("zero flag with nonzero result");
  end
endmodule

// File: tb/slt_alu_tb.sv
module slt_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA, opB;
  logic [3:0]  opCode;
  logic [31:0] result;
  logic        zeroFlag, overflow;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  slt_alu u_dut (.opA(opA), .opB(opB), .opCode(opCode),
                 .result(result), .zeroFlag(zeroFlag), .overflow(overflow));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s op=%b a=%h b=%h got=%h exp=%h", req, opCode, opA, opB, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opCode = c; opA = a; opB = b;
    #1;
  endtask

  // R1, R2 with several patterns
  task automatic test_logic(input logic [31:0] a, input logic [31:0] b);
    apply(4'b0000, a, b);
    check("R1", result, a & b);
    check("R8", {31'b0, zeroFlag}, {31'b0, (a & b) == 0});
    check("R7", {31'b0, overflow}, 32'b0);
    apply(4'b0001, a, b);
    check("R2", result, a | b);
    check("R7", {31'b0, overflow}, 32'b0);
  endtask

  task automatic test_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = a + b;
    apply(4'b0010, a, b);
    check("R3", result, s);
    check("R6", {31'b0, overflow}, {31'b0, (a[31] == b[31]) && (s[31] != a[31])});
    check("R8", {31'b0, zeroFlag}, {31'b0, s == 0});
  endtask

  task automatic test_sub(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    apply(4'b0110, a, b);
    check("R4", result, d);
    check("R6", {31'b0, overflow}, {31'b0, (a[31] != b[31]) && (d[31] != a[31])});
    check("R8", {31'b0, zeroFlag}, {31'b0, d == 0});
  endtask

  task automatic test_slt(input logic [31:0] a, input logic [31:0] b);
    logic lt;
    lt = $signed(a) < $signed(b);
    apply(4'b0111, a, b);
    check("R5", result, {31'b0, lt});
    check("R7", {31'b0, overflow}, 32'b0);
    check("R8", {31'b0, zeroFlag}, {31'b0, !lt});
  endtask

  task automatic test_unlisted(input logic [3:0] c);
    apply(c, 32'hFFFF_FFFF, 32'h8000_0001);
    check("R9", result, 32'b0);
    check("R9", {31'b0, zeroFlag}, 32'b1);
    check("R7", {31'b0, overflow}, 32'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired got=hung exp=done");
    finish_run();
  end

  initial begin
    opA = '0; opB = '0; opCode = 4'b0000;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    check("R8", {31'b0, zeroFlag}, 32'b1);   // reset-time idle state: AND of zeros
    check("R1", result, 32'b0);

    test_logic(32'hF0F0_1234, 32'h0FF0_FF00);
    test_logic(32'hAAAA_AAAA, 32'h5555_5555);
    test_logic(32'hFFFF_FFFF, 32'h8001_0001);

    test_add(32'd7, 32'd9);
    test_add(32'hFFFF_FFFF, 32'd1);          // carry through every slice
    test_add(32'h7FFF_FFFF, 32'd1);          // positive overflow
    test_add(32'h8000_0000, 32'h8000_0000);  // negative overflow, zero result

    test_sub(32'd100, 32'd100);              // equality -> zero
    test_sub(32'd0, 32'd1);                  // borrow through every slice
    test_sub(32'h8000_0000, 32'd1);          // overflow
    test_sub(32'h7FFF_FFFF, 32'hFFFF_FFFF);  // overflow

    test_slt(32'd3, 32'd5);
    test_slt(32'd5, 32'd3);
    test_slt(32'hFFFF_FFFF, 32'd0);
    test_slt(32'h8000_0000, 32'd1);          // subtraction overflows
    test_slt(32'h7FFF_FFFF, 32'hFFFF_FFFF);  // subtraction overflows
    test_slt(32'd42, 32'd42);

    test_unlisted(4'b0011);
    test_unlisted(4'b1111);
    test_unlisted(4'b0100);

    finish_run();
  end
endmodule